// File: doc/BRIEF.md
# Asynchronous SRAM Bus Master with Store-Busy Hold-Off

This block is a clocked host-side controller for a byte-wide asynchronous static RAM with 2048 locations. A client hands it one read or one write at a time over a valid/ready request port. The controller turns each request into an SRAM bus cycle. It drives the address, the active-low chip-enable, output-enable and write-enable strobes, and a split data bus that has separate outgoing data, incoming data and an output-enable for the pad. Read data returns on a one-cycle response pulse.

Each phase length is a whole number of clock cycles. The controller derives these counts at elaboration from a clock-period parameter and a speed-grade parameter, which selects the 25 ns or the 45 ns timing set. The memory has an active-low store/busy line. The controller passes this line through a two-stage synchroniser. While the synchronised line is low, the controller starts no new bus cycle. A cycle that is already running when the line falls still completes.

Top module: `sram_bus_master`

## Requirements
- R1: During reset and immediately after it, chip-enable, output-enable and write-enable are high, the data pad enable is low, the response pulse is low and request-ready is low.
- R2: The read access phase lasts RD = ceil(t_access / T_clk) cycles. The write strobe lasts WP = ceil(max(write pulse, address-to-end-of-write, data setup) / T_clk) cycles. Write recovery lasts max(1, ceil(t_write_cycle / T_clk) − WP) cycles. With a 4 ns clock, the fast grade gives RD=7, WP=5 and recovery 2, and the slow grade gives 12, 8 and 4.
- R3: A read holds chip-enable and output-enable low and write-enable high for exactly RD cycles, starting in the cycle after the request is accepted.
- R4: Read data is sampled from the incoming data bus on the clock edge that ends the access phase. It is presented on the response data together with a response-valid pulse that lasts exactly one cycle.
- R5: A write holds chip-enable and write-enable low for exactly WP cycles, starting the cycle after acceptance. Output-enable stays high for the whole write. All three strobes are then high for the recovery cycles.
- R6: The data pad enable is high in exactly the WP strobe cycles and the first recovery cycle, and the outgoing data equals the accepted write data during that window. At every other time the pad enable is low.
- R7: The address driven to the memory equals the accepted request address and stays unchanged through the whole strobe phase and the write recovery.
- R8: Request-ready is high only when no bus cycle is in progress. A request is taken on a clock edge where request-valid and request-ready are both high, and at no other edge.
- R9: The store/busy input passes through two flip-flops that reset to the busy state. Request-ready is low whenever the synchronised value is low, so request-ready rises two cycles after the busy line returns high.
- R10: A bus cycle that has already started runs to completion with normal timing when the busy line falls during it, and the data it writes is kept.
- R11: Request-ready is high in the cycle that carries the read response, so a request held valid is taken there and its strobes start in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 11 | Byte address of the request |
| req_wdata | input | 8 | Data for a write request |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Data returned by the last read |
| mem_addr | output | 11 | Address to the memory |
| mem_dq_o | output | 8 | Data driven onto the memory data bus |
| mem_dq_oe | output | 1 | High when the data bus pad is driven |
| mem_dq_i | input | 8 | Data read from the memory data bus |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_busy_n | input | 1 | Store/busy line from the memory, low while busy |

## Verification
The bench memory model returns junk data until the access time has elapsed since the read strobes fell. If the access count were rounded down, or data were sampled one edge early, reads would return that junk. Every write is read back, including at the lowest and highest address. A controller that dropped the pad enable before write-enable rose, or lowered output-enable during a write, would lose the data or be flagged on the strobe comparison. The busy line is pulled low both before a request and in the middle of a write strobe. A design without the synchroniser delay, or one that aborted an active cycle, would show a ready or strobe mismatch in that window. Reads are also issued back to back with valid held high, so a controller that inserted an idle cycle after each response would fall out of step with the reference model.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Bus cycle phase of the sequencer.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_READ    = 2'd1,
    PH_WSTROBE = 2'd2,
    PH_WREC    = 2'd3
  } phase_e;

  // Memory-side control strobes, registered together.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Nanoseconds to clock cycles, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Remaining part of a cycle time after a phase, never below one cycle.
  function automatic int unsigned rest_min1(input int unsigned total, input int unsigned used);
    return (total > used) ? (total - used) : 1;
  endfunction
endpackage

// File: rtl/sram_busy_sync.sv
module sram_busy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_n_async,
  output logic idle_sync
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = busy_n_async;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], busy_n_async};
    end
  endgenerate

  // Resets to the busy state so nothing starts before the line is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign idle_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_bus_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 5,
  parameter int unsigned REC_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             bus_idle,
  input  logic             timer_last,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             ready,
  output logic             accept,
  output logic             capture_rd,
  output strobe_t          strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  phase_e  state_q, state_d;
  logic    rec_first_d;
  strobe_t strobe_q, strobe_d;

  assign ready  = (state_q == PH_IDLE) && bus_idle;
  assign accept = req_valid && ready;

  always_comb begin
    state_d     = state_q;
    timer_load  = 1'b0;
    timer_val   = '0;
    capture_rd  = 1'b0;
    rec_first_d = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (accept) begin
          timer_load = 1'b1;
          if (req_write) begin
            state_d   = PH_WSTROBE;
            timer_val = CNT_W'(WP_CYC - 1);
          end else begin
            state_d   = PH_READ;
            timer_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      PH_READ: begin
        if (timer_last) begin
          state_d    = PH_IDLE;
          capture_rd = 1'b1;
        end
      end
      PH_WSTROBE: begin
        if (timer_last) begin
          state_d     = PH_WREC;
          timer_load  = 1'b1;
          timer_val   = CNT_W'(REC_CYC - 1);
          rec_first_d = 1'b1;
        end
      end
      PH_WREC: begin
        if (timer_last) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // Strobes decoded from the next phase and registered, so pins change only at edges.
  always_comb begin
    strobe_d       = STROBE_QUIET;
    strobe_d.ce_n  = !((state_d == PH_READ) || (state_d == PH_WSTROBE));
    strobe_d.oe_n  = (state_d != PH_READ);
    strobe_d.we_n  = (state_d != PH_WSTROBE);
    strobe_d.dq_oe = (state_d == PH_WSTROBE) || rec_first_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      strobe_q <= STROBE_QUIET;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe = strobe_q;
endmodule

// File: rtl/sram_bus_master.sv
module sram_bus_master
  import sram_bus_pkg::*;
#(
  parameter bit          SPEED_FAST    = 1'b1,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic              mem_busy_n
);
  timeunit 1ns;
  timeprecision 1ps;

  // Speed-grade timing set, nanoseconds.
  localparam int unsigned T_ACC_NS = SPEED_FAST ? 25 : 45;
  localparam int unsigned T_OEA_NS = SPEED_FAST ? 10 : 20;
  localparam int unsigned T_RC_NS  = SPEED_FAST ? 25 : 45;
  localparam int unsigned T_WP_NS  = SPEED_FAST ? 20 : 30;
  localparam int unsigned T_AW_NS  = SPEED_FAST ? 20 : 30;
  localparam int unsigned T_DS_NS  = SPEED_FAST ? 10 : 15;
  localparam int unsigned T_WC_NS  = SPEED_FAST ? 25 : 45;

  localparam int unsigned RD_CYC  = max2(max2(ns_to_cyc(T_ACC_NS, CLK_PERIOD_PS),
                                              ns_to_cyc(T_OEA_NS, CLK_PERIOD_PS)),
                                         ns_to_cyc(T_RC_NS, CLK_PERIOD_PS));
  localparam int unsigned WP_CYC  = max2(max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_PS),
                                              ns_to_cyc(T_AW_NS, CLK_PERIOD_PS)),
                                         ns_to_cyc(T_DS_NS, CLK_PERIOD_PS));
  localparam int unsigned REC_CYC = rest_min1(ns_to_cyc(T_WC_NS, CLK_PERIOD_PS), WP_CYC);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), REC_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             bus_idle;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_last;
  logic             accept;
  logic             capture_rd;
  strobe_t          strobe;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  sram_busy_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_n_async (mem_busy_n),
    .idle_sync    (bus_idle)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .last     (timer_last)
  );

  sram_cycle_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .bus_idle   (bus_idle),
    .timer_last (timer_last),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .ready      (req_ready),
    .accept     (accept),
    .capture_rd (capture_rd),
    .strobe     (strobe)
  );

  // Request capture, with explicit clock enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wdata_q <= '0;
    else if (accept && req_write) wdata_q <= req_wdata;
  end

  // Read data sampled on the edge that closes the access phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (capture_rd) rdata_q <= mem_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= capture_rd;
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = strobe.dq_oe ? wdata_q : '0;
  assign mem_dq_oe = strobe.dq_oe;
  assign mem_ce_n  = strobe.ce_n;
  assign mem_oe_n  = strobe.oe_n;
  assign mem_we_n  = strobe.we_n;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sram_bus_master_chk.sv
module sram_bus_master_chk
  import sram_bus_pkg::*;
#(
  parameter bit          SPEED_FAST    = 1'b1,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned ADDR_W        = 11,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_busy_n
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned RD_EXP = ns_to_cyc(SPEED_FAST ? 25 : 45, CLK_PERIOD_PS);
  localparam int unsigned WP_EXP = ns_to_cyc(SPEED_FAST ? 20 : 30, CLK_PERIOD_PS);

  logic [7:0] we_run, oe_run, low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run  <= '0;
      oe_run  <= '0;
      low_run <= '0;
    end else begin
      we_run  <= !mem_we_n ? we_run + 8'd1 : 8'd0;
      oe_run  <= !mem_oe_n ? oe_run + 8'd1 : 8'd0;
      if (mem_busy_n)            low_run <= 8'd0;
      else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R5

  AST_DQ_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R7

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe)); // R8

  AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run >= 8'(SYNC_STAGES)) |-> !req_ready); // R9

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 8'(WP_EXP))); // R2

  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == 8'(RD_EXP))); // R3
endmodule

bind sram_bus_master sram_bus_master_chk #(
  .SPEED_FAST    (SPEED_FAST),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .ADDR_W        (ADDR_W),
  .SYNC_STAGES   (SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_busy_n (mem_busy_n)
);

// File: tb/sram_bus_master_tb_top.sv
module sram_bus_master_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam bit FAST   = 1'b1;
  localparam int PER_PS = 4000;
  localparam int ACC_NS = FAST ? 25 : 45;
  localparam int RD_N   = (ACC_NS * 1000 + PER_PS - 1) / PER_PS;
  localparam int WP_N   = ((FAST ? 20 : 30) * 1000 + PER_PS - 1) / PER_PS;
  localparam int WC_N   = ((FAST ? 25 : 45) * 1000 + PER_PS - 1) / PER_PS;
  localparam int REC_N  = (WC_N > WP_N) ? (WC_N - WP_N) : 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        mem_busy_n = 1'b1;
  logic [7:0]  mem_dq_i = 8'h00;
  logic        req_ready, rsp_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  rsp_rdata, mem_dq_o;
  logic [10:0] mem_addr;

  always #2 clk = ~clk;

  sram_bus_master #(.SPEED_FAST(FAST), .CLK_PERIOD_PS(PER_PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_busy_n(mem_busy_n)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endfunction

  // Memory model: data becomes valid only once the access time has elapsed.
  logic [7:0]  mem_arr [0:2047];
  logic [7:0]  shadow  [0:2047];
  int          rd_age = 0;
  bit          we_low_prev = 1'b0;
  logic [10:0] wr_a_l = '0;
  logic [7:0]  wr_d_l = '0;

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem_arr[i] = 8'(i) ^ 8'h3C;
      shadow[i]  = 8'(i) ^ 8'h3C;
    end
  end

  // Reference model state, advanced on every rising edge.
  int   m_mode = 0;   // 0 idle, 1 read, 2 write strobe, 3 write recovery
  int   m_left = 0;
  bit   m_first = 1'b0;
  bit   m_rsp = 1'b0;
  logic [10:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  logic [7:0]  m_rdata = '0;
  bit   bq[$] = '{1'b0, 1'b0};
  bit   m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_first = 1'b0; m_rsp = 1'b0;
      bq = '{1'b0, 1'b0};
    end else begin
      m_acc = req_valid && (m_mode == 0) && bq[0];
      m_rsp = 1'b0;
      case (m_mode)
        0: if (m_acc) begin
             m_addr = req_addr;
             if (req_write) begin
               m_mode = 2; m_left = WP_N; m_wd = req_wdata;
               shadow[req_addr] = req_wdata;
             end else begin
               m_mode = 1; m_left = RD_N;
             end
           end
        1: if (m_left > 1) m_left--;
           else begin m_rsp = 1'b1; m_rdata = shadow[m_addr]; m_mode = 0; end
        2: if (m_left > 1) m_left--;
           else begin m_mode = 3; m_left = REC_N; m_first = 1'b1; end
        default: begin
           m_first = 1'b0;
           if (m_left > 1) m_left--; else m_mode = 0;
        end
      endcase
      void'(bq.pop_front());
      bq.push_back(mem_busy_n);
    end
  end

  // Memory model and per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++; else rd_age = 0;
    mem_dq_i = (rd_age * PER_PS >= ACC_NS * 1000) ? mem_arr[mem_addr] : 8'hEE;
    if (we_low_prev && mem_we_n) mem_arr[wr_a_l] = wr_d_l;
    if (!mem_we_n && !mem_ce_n && mem_dq_oe) begin wr_a_l = mem_addr; wr_d_l = mem_dq_o; end
    we_low_prev = !mem_we_n;

    if (rst_n && !finished) begin
      chk(m_rsp ? "R11 ready in response cycle" : "R8/R9 ready",
          {31'd0, req_ready}, {31'd0, (m_mode == 0) && bq[0]});
      chk("R3/R5 ce_n", {31'd0, mem_ce_n}, {31'd0, !(m_mode == 1 || m_mode == 2)});
      chk("R3/R5 oe_n", {31'd0, mem_oe_n}, {31'd0, m_mode != 1});
      chk("R2/R5 we_n", {31'd0, mem_we_n}, {31'd0, m_mode != 2});
      chk("R6 dq_oe", {31'd0, mem_dq_oe}, {31'd0, (m_mode == 2) || (m_mode == 3 && m_first)});
      if (m_mode == 2 || (m_mode == 3 && m_first))
        chk("R6 dq_o", {24'd0, mem_dq_o}, {24'd0, m_wd});
      if (m_mode != 0)
        chk("R7 addr", {21'd0, mem_addr}, {21'd0, m_addr});
      chk("R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp});
      if (m_rsp)
        chk("R4 rsp_rdata", {24'd0, rsp_rdata}, {24'd0, m_rdata});
    end
  end

  task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic read_chk(input logic [10:0] a, input logic [7:0] exp, input string tag);
    issue(1'b0, a, 8'h00);
    while (!rsp_valid) @(negedge clk);
    chk(tag, {24'd0, rsp_rdata}, {24'd0, exp});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: quiet bus during reset
    repeat (3) @(negedge clk);
    chk("R1 ce_n in reset", {31'd0, mem_ce_n}, 32'd1);
    chk("R1 oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
    chk("R1 we_n in reset", {31'd0, mem_we_n}, 32'd1);
    chk("R1 dq_oe in reset", {31'd0, mem_dq_oe}, 32'd0);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready right after reset", {31'd0, req_ready}, 32'd0);

    // Address corners and data patterns, then read back.
    do_write(11'h000, 8'h5A);
    do_write(11'h7FF, 8'hA5);
    do_write(11'h155, 8'hFF);
    do_write(11'h2AA, 8'h00);
    read_chk(11'h000, 8'h5A, "R5 readback lowest address");
    read_chk(11'h7FF, 8'hA5, "R5 readback highest address");
    read_chk(11'h155, 8'hFF, "R6 readback all ones");
    read_chk(11'h2AA, 8'h00, "R6 readback all zeros");
    read_chk(11'h123, 8'h23 ^ 8'h3C, "R2 untouched location after access time");

    // R11: reads with valid held high across responses.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0;
    for (int k = 0; k < 4; k++) begin
      req_addr = 11'(k * 300 + 7);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);

    // R9: busy low before a request holds it off.
    @(negedge clk);
    mem_busy_n = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h0F0; req_wdata = 8'hC3;
    repeat (12) @(negedge clk);
    chk("R9 no strobe while busy", {31'd0, mem_ce_n}, 32'd1);
    mem_busy_n = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    read_chk(11'h0F0, 8'hC3, "R9 held write lands after busy clears");

    // R10: busy falls in the middle of a write strobe.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h333; req_wdata = 8'h96;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mem_busy_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 strobes quiet after write finished", {31'd0, mem_we_n}, 32'd1);
    mem_busy_n = 1'b1;
    while (!req_ready) @(negedge clk);
    read_chk(11'h333, 8'h96, "R10 write completed despite busy");

    // Mixed traffic with pseudo-random addresses and data.
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 24; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) do_write(lf[10:0], lf[15:8]);
        else       read_chk(lf[10:0], shadow[lf[10:0]], "R4 mixed traffic read");
      end
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule